// File: doc/BRIEF.md
# Two-Thread Tagged Trace Lookup Cache

This block is a small set-associative lookup store shared by two hardware threads. Each thread presents its own next-fetch pointer and a request bit. An arbiter picks one thread per clock. The granted pointer is looked up in the array, and the result comes back one cycle later: a hit or miss flag, the thread it belongs to and the stored payload word. Every stored line records the thread that installed it. A thread therefore never hits on a line that belongs to the other thread, even when the address is the same.

On a miss the surrounding logic installs the line through a fill port, which carries a thread, an address and an opaque payload word. A fill goes into the lowest-numbered invalid way of the set. When the set is full, the fill evicts the least recently used way of the eight. The block reports which way was written one cycle after the fill.

The arbiter is a two-state machine. The states are ARB_FAVOR_T0 and ARB_FAVOR_T1, and they say which thread wins the next contended cycle. There is one transition each way: from ARB_FAVOR_T0 to ARB_FAVOR_T1, and back from ARB_FAVOR_T1 to ARB_FAVOR_T0. Each is taken only in a cycle where both threads request and no fill is present. Every other cycle holds the current state.

Top module: `trace_cache`

## Requirements
- R1: A synchronous active-high reset invalidates every line, leaves `rsp_vld` and `fill_ack` low in the cycle after reset, and makes every later lookup miss until a fill occurs.
- R2: When exactly one thread requests and no fill is present, that thread is granted whatever the arbiter state, and the arbiter state does not change.
- R3: When both threads request and no fill is present, the favoured thread is granted and the other thread becomes favoured. Consecutive contended cycles therefore alternate, and the first contended grant after reset goes to thread 0.
- R4: A fill has priority over lookups. In a cycle with `fill_vld` high, no thread is granted, `rsp_vld` is low in the next cycle, and the arbiter state is unchanged.
- R5: A lookup granted in cycle N is reported in cycle N+1. In that cycle `rsp_vld` is 1, `rsp_tid` is the granted thread (0 or 1), and `rsp_hit` is 1 only if the line is present, in which case `rsp_data` is the word installed by its fill. With no request, `rsp_vld` is 0.
- R6: A hit requires a valid line whose stored tag and stored thread both match the requester. A line filled by one thread misses for the other thread.
- R7: The set index is `addr[OFFSET_W +: SET_W]` and the tag is `addr[ADDR_W-1 : OFFSET_W+SET_W]`. The low `OFFSET_W` bits are ignored, so addresses that differ only there hit the same line.
- R8: A fill writes the lowest-numbered invalid way of its set. In the next cycle `fill_ack` is 1 and `fill_way` holds the way written.
- R9: In a full set, a fill evicts the least recently used way. Both a hit and a fill make the accessed way the most recently used. After reset, the recency order makes way 0 the oldest and way 7 the newest.
- R10: One thread can hold eight distinct tags in one set at the same time, and all eight hit.
- R11: A lookup that misses leaves the recency order of its set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_t0 | input | 1 | Thread 0 lookup request |
| addr_t0 | input | ADDR_W | Thread 0 next-fetch pointer |
| req_t1 | input | 1 | Thread 1 lookup request |
| addr_t1 | input | ADDR_W | Thread 1 next-fetch pointer |
| fill_vld | input | 1 | Install a line this cycle |
| fill_tid | input | 1 | Thread that owns the new line |
| fill_addr | input | ADDR_W | Address of the new line |
| fill_data | input | DATA_W | Payload word of the new line |
| rsp_vld | output | 1 | A lookup result is present |
| rsp_tid | output | 1 | Thread of the result |
| rsp_hit | output | 1 | The lookup hit |
| rsp_data | output | DATA_W | Payload on a hit, zero otherwise |
| fill_ack | output | 1 | A fill completed in the previous cycle |
| fill_way | output | $clog2(WAYS) | Way written by the last fill |

## Verification
The bench builds the block with ADDR_W=8, OFFSET_W=2, SETS=2, WAYS=8 and DATA_W=16. That gives a 5-bit tag, two sets and four offsets. A pool of twelve tags per set and two threads then overflows the eight ways quickly, so invalid-first placement, LRU eviction, cross-thread misses and every arbiter state and transition all occur within a few thousand cycles. Directed sequences pin the boundary cases, and a long mixed sweep is compared against a timestamp-based recency model kept in the bench.

// File: rtl/tc_pkg.sv
package tc_pkg;

    // Arbiter state: which thread wins the next contended cycle
    typedef enum logic [0:0] {
        ARB_FAVOR_T0 = 1'b0,
        ARB_FAVOR_T1 = 1'b1
    } arb_state_e;

endpackage

// File: rtl/tc_arbiter.sv
module tc_arbiter
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       hold,
    output logic       gnt_vld,
    output logic       gnt_tid
);

    arb_state_e st_q, st_d;
    logic       contended;

    assign contended = !hold && req[0] && req[1];

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ARB_FAVOR_T0;
        else     st_q <= st_d;
    end

    // Next state: flips only on a contended cycle
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_FAVOR_T0: if (contended) st_d = ARB_FAVOR_T1;
            ARB_FAVOR_T1: if (contended) st_d = ARB_FAVOR_T0;
            default:      st_d = ARB_FAVOR_T0;
        endcase
    end

    // Outputs
    always_comb begin
        gnt_vld = !hold && (req[0] || req[1]);
        gnt_tid = req[1];
        unique case (st_q)
            ARB_FAVOR_T0: if (req[0] && req[1]) gnt_tid = 1'b0;
            ARB_FAVOR_T1: if (req[0] && req[1]) gnt_tid = 1'b1;
            default:      gnt_tid = req[1];
        endcase
    end

endmodule

// File: rtl/tc_lru.sv
module tc_lru #(
    parameter int SETS = 16,
    parameter int WAYS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    touch_en,
    input  logic [$clog2(SETS)-1:0] touch_set,
    input  logic [$clog2(WAYS)-1:0] touch_way,
    input  logic [$clog2(SETS)-1:0] vic_set,
    output logic [$clog2(WAYS)-1:0] vic_way
);

    localparam int SET_W = $clog2(SETS);
    localparam int AGE_W = $clog2(WAYS);

    // Per-set age vector: 0 = most recent, WAYS-1 = least recent
    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] ages;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAYS-1:0][AGE_W-1:0] age_q;
        logic                       sel;

        assign sel = touch_en && (touch_set == SET_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WAYS; w++)
                    age_q[w] <= AGE_W'(WAYS - 1 - w);
            end else if (sel) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (AGE_W'(w) == touch_way)
                        age_q[w] <= '0;
                    else if (age_q[w] < age_q[touch_way])
                        age_q[w] <= age_q[w] + AGE_W'(1);
                end
            end
        end

        assign ages[s] = age_q;
    end

    // The oldest way carries the maximum age
    always_comb begin
        vic_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (ages[vic_set][w] == AGE_W'(WAYS - 1))
                vic_way = AGE_W'(w);
    end

endmodule

// File: rtl/tc_tag_array.sv
module tc_tag_array #(
    parameter int SETS   = 16,
    parameter int WAYS   = 8,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    // lookup
    input  logic [$clog2(SETS)-1:0] lk_set,
    input  logic [TAG_W-1:0]        lk_tag,
    input  logic                    lk_tid,
    output logic                    lk_hit,
    output logic [$clog2(WAYS)-1:0] lk_way,
    output logic [DATA_W-1:0]       lk_data,
    // free-way probe
    input  logic [$clog2(SETS)-1:0] probe_set,
    output logic                    inv_found,
    output logic [$clog2(WAYS)-1:0] inv_way,
    // write
    input  logic                    wr_en,
    input  logic [$clog2(SETS)-1:0] wr_set,
    input  logic [$clog2(WAYS)-1:0] wr_way,
    input  logic [TAG_W-1:0]        wr_tag,
    input  logic                    wr_tid,
    input  logic [DATA_W-1:0]       wr_data
);

    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAYS-1:0] valid_q;
    logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
    logic                      tid_q  [SETS][WAYS];
    logic [DATA_W-1:0]         data_q [SETS][WAYS];
    logic [WAYS-1:0]           way_match;

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= '0;
        else if (wr_en)
            valid_q[wr_set][wr_way] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_set][wr_way]  <= wr_tag;
            tid_q[wr_set][wr_way]  <= wr_tid;
            data_q[wr_set][wr_way] <= wr_data;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = valid_q[lk_set][w]
                           && (tag_q[lk_set][w] == lk_tag)
                           && (tid_q[lk_set][w] == lk_tid);
    end

    assign lk_hit = |way_match;

    always_comb begin
        lk_way  = '0;
        lk_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) begin
                lk_way  = WAY_W'(w);
                lk_data = data_q[lk_set][w];
            end
        end
    end

    // Lowest-numbered invalid way (scan downward, last match wins)
    always_comb begin
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[probe_set][w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/trace_cache.sv
module trace_cache #(
    parameter int ADDR_W   = 16,
    parameter int OFFSET_W = 2,
    parameter int SETS     = 16,
    parameter int WAYS     = 8,
    parameter int DATA_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_t0,
    input  logic [ADDR_W-1:0]       addr_t0,
    input  logic                    req_t1,
    input  logic [ADDR_W-1:0]       addr_t1,
    input  logic                    fill_vld,
    input  logic                    fill_tid,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [DATA_W-1:0]       fill_data,
    output logic                    rsp_vld,
    output logic                    rsp_tid,
    output logic                    rsp_hit,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    fill_ack,
    output logic [$clog2(WAYS)-1:0] fill_way
);

    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = ADDR_W - OFFSET_W;
    localparam int TAG_W  = LINE_W - SET_W;

    logic              gnt_vld, gnt_tid;
    logic [ADDR_W-1:0] sel_addr;
    logic [SET_W-1:0]  lk_set, fl_set;
    logic [TAG_W-1:0]  lk_tag, fl_tag;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way, inv_way, lru_way, fl_way;
    logic [DATA_W-1:0] lk_data;
    logic              inv_found;

    tc_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     ({req_t1, req_t0}),
        .hold    (fill_vld),
        .gnt_vld (gnt_vld),
        .gnt_tid (gnt_tid)
    );

    assign sel_addr          = gnt_tid ? addr_t1 : addr_t0;
    assign {lk_tag, lk_set}  = LINE_W'(sel_addr  >> OFFSET_W);
    assign {fl_tag, fl_set}  = LINE_W'(fill_addr >> OFFSET_W);
    assign fl_way            = inv_found ? inv_way : lru_way;

    tc_tag_array #(
        .SETS   (SETS),
        .WAYS   (WAYS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_arr (
        .clk       (clk),
        .rst       (rst),
        .lk_set    (lk_set),
        .lk_tag    (lk_tag),
        .lk_tid    (gnt_tid),
        .lk_hit    (lk_hit),
        .lk_way    (lk_way),
        .lk_data   (lk_data),
        .probe_set (fl_set),
        .inv_found (inv_found),
        .inv_way   (inv_way),
        .wr_en     (fill_vld),
        .wr_set    (fl_set),
        .wr_way    (fl_way),
        .wr_tag    (fl_tag),
        .wr_tid    (fill_tid),
        .wr_data   (fill_data)
    );

    tc_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (fill_vld || (gnt_vld && lk_hit)),
        .touch_set (fill_vld ? fl_set : lk_set),
        .touch_way (fill_vld ? fl_way : lk_way),
        .vic_set   (fl_set),
        .vic_way   (lru_way)
    );

    // Response and fill-report registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_tid  <= 1'b0;
            rsp_hit  <= 1'b0;
            rsp_data <= '0;
            fill_ack <= 1'b0;
            fill_way <= '0;
        end else begin
            rsp_vld  <= gnt_vld;
            rsp_tid  <= gnt_tid;
            rsp_hit  <= gnt_vld && lk_hit;
            rsp_data <= (gnt_vld && lk_hit) ? lk_data : '0;
            fill_ack <= fill_vld;
            if (fill_vld) fill_way <= fl_way;
        end
    end

endmodule

// File: rtl/tc_checker.sv
module tc_checker (
    input logic clk,
    input logic rst,
    input logic req_t0,
    input logic req_t1,
    input logic fill_vld,
    input logic rsp_vld,
    input logic rsp_tid,
    input logic rsp_hit,
    input logic fill_ack
);

    logic both_free;
    assign both_free = req_t0 && req_t1 && !fill_vld;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !rsp_vld && !fill_ack);

    // R2
    lone_t0_grant_chk: assert property (@(posedge clk) disable iff (rst)
        req_t0 && !req_t1 && !fill_vld |=> rsp_vld && !rsp_tid);

    // R2
    lone_t1_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !req_t0 && req_t1 && !fill_vld |=> rsp_vld && rsp_tid);

    // R3
    contend_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_vld && both_free && $past(both_free) |=> rsp_vld && (rsp_tid != $past(rsp_tid)));

    // R4
    fill_blocks_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        fill_vld |=> !rsp_vld && fill_ack);

    // R5
    idle_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_t0 && !req_t1 |=> !rsp_vld);

    // R5
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_vld);

endmodule

bind trace_cache tc_checker u_tc_checker (
    .clk      (clk),
    .rst      (rst),
    .req_t0   (req_t0),
    .req_t1   (req_t1),
    .fill_vld (fill_vld),
    .rsp_vld  (rsp_vld),
    .rsp_tid  (rsp_tid),
    .rsp_hit  (rsp_hit),
    .fill_ack (fill_ack)
);

// File: tb/test_trace_cache.sv
module test_trace_cache;

    localparam int AW = 8;
    localparam int OW = 2;
    localparam int NS = 2;
    localparam int NW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_t0 = 1'b0, req_t1 = 1'b0;
    logic [AW-1:0] addr_t0 = '0, addr_t1 = '0;
    logic          fill_vld = 1'b0, fill_tid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [DW-1:0] fill_data = '0;
    logic          rsp_vld, rsp_tid, rsp_hit, fill_ack;
    logic [DW-1:0] rsp_data;
    logic [2:0]    fill_way;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model
    bit mv [NS][NW];
    bit mt [NS][NW];
    int mtag [NS][NW];
    int mdat [NS][NW];
    int mstamp [NS][NW];
    int now;
    bit favor;
    int unsigned seed = 32'h1234_5678;

    trace_cache #(
        .ADDR_W (AW), .OFFSET_W (OW), .SETS (NS), .WAYS (NW), .DATA_W (DW)
    ) i_trace_cache (
        .clk (clk), .rst (rst),
        .req_t0 (req_t0), .addr_t0 (addr_t0),
        .req_t1 (req_t1), .addr_t1 (addr_t1),
        .fill_vld (fill_vld), .fill_tid (fill_tid),
        .fill_addr (fill_addr), .fill_data (fill_data),
        .rsp_vld (rsp_vld), .rsp_tid (rsp_tid), .rsp_hit (rsp_hit),
        .rsp_data (rsp_data), .fill_ack (fill_ack), .fill_way (fill_way)
    );

    always #4 clk = ~clk;

    function automatic int set_of(int a); return (a >> 2) & 1; endfunction
    function automatic int tag_of(int a); return a >> 3; endfunction
    function automatic int mk(int tag, int s, int off); return (tag << 3) | (s << 2) | off; endfunction

    function automatic int m_find(int tid, int a);
        for (int w = 0; w < NW; w++)
            if (mv[set_of(a)][w] && mt[set_of(a)][w] == bit'(tid) && mtag[set_of(a)][w] == tag_of(a))
                return w;
        return -1;
    endfunction

    function automatic int m_victim(int s);
        int best;
        for (int w = 0; w < NW; w++)
            if (!mv[s][w]) return w;
        best = 0;
        for (int w = 1; w < NW; w++)
            if (mstamp[s][w] < mstamp[s][best]) best = w;
        return best;
    endfunction

    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input bit ok, input string r, input int act, input int exp, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // One clock of stimulus; starts and ends at a falling edge
    task automatic step(input bit r0, input int a0, input bit r1, input int a1,
                        input bit f, input bit ft, input int fa, input int fd, input string r);
        bit g_vld, g_tid;
        int ga, hw, fw, fs;
        g_vld = !f && (r0 || r1);
        g_tid = (r0 && r1) ? favor : r1;
        ga    = g_tid ? a1 : a0;
        hw    = g_vld ? m_find(int'(g_tid), ga) : -1;
        fs    = set_of(fa);
        fw    = f ? m_victim(fs) : 0;
        req_t0 = r0; addr_t0 = AW'(a0);
        req_t1 = r1; addr_t1 = AW'(a1);
        fill_vld = f; fill_tid = ft; fill_addr = AW'(fa); fill_data = DW'(fd);
        @(negedge clk);
        chk(rsp_vld === g_vld, r, int'(rsp_vld), int'(g_vld), "rsp_vld");
        if (g_vld) begin
            chk(rsp_tid === g_tid, r, int'(rsp_tid), int'(g_tid), "rsp_tid");
            chk(rsp_hit === (hw >= 0), r, int'(rsp_hit), int'(hw >= 0), "rsp_hit");
            if (hw >= 0)
                chk(rsp_data === DW'(mdat[set_of(ga)][hw]), r, int'(rsp_data),
                    mdat[set_of(ga)][hw], "rsp_data");
        end
        chk(fill_ack === f, r, int'(fill_ack), int'(f), "fill_ack");
        if (f) begin
            chk(fill_way === 3'(fw), r, int'(fill_way), fw, "fill_way");
            mv[fs][fw] = 1'b1; mt[fs][fw] = ft; mtag[fs][fw] = tag_of(fa);
            mdat[fs][fw] = fd & 16'hffff; mstamp[fs][fw] = now++;
        end else if (hw >= 0) begin
            mstamp[set_of(ga)][hw] = now++;
        end
        if (!f && r0 && r1) favor = !favor;
        req_t0 = 1'b0; req_t1 = 1'b0; fill_vld = 1'b0;
    endtask

    task automatic look(input bit tid, input int a, input string r);
        if (tid) step(1'b0, 0, 1'b1, a, 1'b0, 1'b0, 0, 0, r);
        else     step(1'b1, a, 1'b0, 0, 1'b0, 1'b0, 0, 0, r);
    endtask

    task automatic fill(input bit tid, input int a, input int d, input string r);
        step(1'b0, 0, 1'b0, 0, 1'b1, tid, a, d, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 1'b0; mstamp[s][w] = w;
            end
        now = NW; favor = 1'b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of outputs
        chk(rsp_vld === 1'b0, "R1", int'(rsp_vld), 0, "rsp_vld after reset");
        chk(fill_ack === 1'b0, "R1", int'(fill_ack), 0, "fill_ack after reset");
        // R1: everything misses
        for (int t = 0; t < 4; t++) begin
            look(1'b0, mk(t, t & 1, 0), "R1");
            look(1'b1, mk(t + 5, 0, 3), "R1");
        end

        // R8: invalid ways fill lowest first
        for (int t = 0; t < NW; t++) fill(1'b0, mk(t, 0, 0), 16'h100 + t, "R8");
        // R10: all eight coexist
        for (int t = 0; t < NW; t++) look(1'b0, mk(t, 0, 0), "R10");
        // R6: other thread misses on those lines
        for (int t = 0; t < NW; t++) look(1'b1, mk(t, 0, 0), "R6");
        // R7: offset ignored, set bit matters
        for (int o = 1; o < 4; o++) look(1'b0, mk(3, 0, o), "R7");
        look(1'b0, mk(3, 1, 0), "R7");

        // R9 / R11: touch tag 0, miss lookups, then evict
        look(1'b0, mk(0, 0, 2), "R9");
        look(1'b0, mk(25, 0, 0), "R11");
        look(1'b1, mk(1, 0, 0), "R11");
        fill(1'b0, mk(20, 0, 0), 16'hbeef, "R9");
        look(1'b0, mk(1, 0, 0), "R9");
        look(1'b0, mk(20, 0, 1), "R9");
        fill(1'b1, mk(2, 0, 0), 16'h2222, "R9");
        look(1'b1, mk(2, 0, 0), "R6");
        look(1'b0, mk(3, 0, 0), "R9");

        // R3: contended alternation
        for (int i = 0; i < 6; i++)
            step(1'b1, mk(i, 0, 0), 1'b1, mk(2, 0, 0), 1'b0, 1'b0, 0, 0, "R3");

        // R2: lone requests do not move the arbiter
        step(1'b1, mk(4, 0, 0), 1'b1, mk(2, 0, 0), 1'b0, 1'b0, 0, 0, "R2");
        look(1'b1, mk(2, 0, 0), "R2");
        look(1'b1, mk(2, 0, 0), "R2");
        step(1'b1, mk(4, 0, 0), 1'b1, mk(2, 0, 0), 1'b0, 1'b0, 0, 0, "R2");
        look(1'b0, mk(4, 0, 0), "R2");
        step(1'b1, mk(4, 0, 0), 1'b1, mk(2, 0, 0), 1'b0, 1'b0, 0, 0, "R2");

        // R4: fill beats contending requests and leaves arbiter state alone
        step(1'b1, mk(4, 0, 0), 1'b1, mk(2, 0, 0), 1'b1, 1'b1, mk(9, 1, 0), 16'h0909, "R4");
        step(1'b1, mk(4, 0, 0), 1'b0, 0, 1'b1, 1'b0, mk(9, 1, 0), 16'h0a0a, "R4");
        step(1'b1, mk(4, 0, 0), 1'b1, mk(9, 1, 0), 1'b0, 1'b0, 0, 0, "R4");
        step(1'b1, mk(9, 1, 0), 1'b1, mk(9, 1, 0), 1'b0, 1'b0, 0, 0, "R4");

        // R5: long mixed sweep against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            int a0, a1, fa;
            bit ft;
            r  = rnd();
            a0 = mk(int'((r >> 4) % 12), int'((r >> 8) & 1), int'((r >> 9) & 3));
            a1 = mk(int'((r >> 11) % 12), int'((r >> 15) & 1), int'((r >> 16) & 3));
            ft = r[18];
            fa = ft ? a1 : a0;
            case (r % 5)
                0, 1: begin
                    if (m_find(int'(ft), fa) < 0)
                        step(r[19], a0, r[20], a1, 1'b1, ft, fa, int'(r >> 16), "R5");
                    else
                        look(ft, fa, "R5");
                end
                2: look(1'b0, a0, "R5");
                3: look(1'b1, a1, "R5");
                default: step(1'b1, a0, 1'b1, a1, 1'b0, 1'b0, 0, 0, "R5");
            endcase
            if ((i % 7) == 0) step(1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 0, 0, "R5");
        end

        summary();
        $finish;
    end

endmodule